// File: doc/BRIEF.md
# Multi-word instruction decoder

This block takes a stream of 32-bit instruction words over a valid/ready handshake. It gathers the words of one instruction and presents a single decoded record to the consumer. An instruction is one, two or three words long. The 8-bit opcode in bits 7:0 of the first word alone sets how many immediate words follow. The other fields of the first word hold register codes, a shift count or a signed branch offset, depending on the opcode.

The decoder does not execute anything. It does not read the register file and it does not fetch from memory. Register codes are 1 to 6, for the four general registers, the instruction pointer and the stack pointer. The record stays on the outputs until the consumer takes it, and no new word is accepted while a record is waiting. Unused fields of the record are zero. Padding bits in the first word that the opcode does not use are ignored.

Top module: `instr_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Length in words is 3 for opcode 05. It is 2 for opcodes 01, 03, 06, 07, 10–16, 1A–1C and 60. It is 1 for every other opcode. `out_valid` rises in the cycle after the last word is accepted, and `out_len` reports the length.
- R3: For the two-register opcodes (02, 04, 08, 20–26, 2A–2E), `out_dst` is taken from bits 15:8 of the first word and `out_src` from bits 23:16.
- R4: For the register/immediate opcodes (01, 03, 06, 07, 10–16, 1A–1C) and the single-register opcodes (17, 18, 1F, 61, 62, 72), `out_dst` is taken from bits 15:8. For the immediate forms, `out_imm0` is the second word. Opcode 60 carries only `out_imm0`.
- R5: For opcode 05, `out_imm0` is the second word (the address) and `out_imm1` is the third word (the value).
- R6: For opcodes 1D and 1E, `out_shamt` is taken from bits 23:16 and `out_dst` from bits 15:8, and the length is 1.
- R7: For opcodes 50–56 and 70, `out_offset` is bits 31:8 of the first word, sign-extended from bit 31 to 32 bits.
- R8: Opcodes 71, EE and FF decode with length 1 and with all operand fields zero.
- R9: An undefined opcode sets `out_illegal` and gives length 1, with all operand fields zero.
- R10: A register code of 0 or above 6 in a field that the opcode uses sets `out_illegal`. The length still follows the opcode, and the bad register output reads 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, the record stays stable and `in_ready` stays 0. One accepted transfer clears `out_valid` on the next cycle.
- R12: Bits of the first word that the opcode does not use have no effect on the record, and they never set `out_illegal`. Operand fields that the opcode does not use read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_data | input | 32 | Instruction word |
| in_ready | output | 1 | Decoder takes the word this cycle |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_dst | output | 3 | Destination or only register code |
| out_src | output | 3 | Source register code |
| out_imm0 | output | 32 | First trailing word |
| out_imm1 | output | 32 | Second trailing word |
| out_shamt | output | 8 | Shift count for the shift-by-constant forms |
| out_offset | output | 32 | Sign-extended branch offset |
| out_len | output | 2 | Instruction length in words |
| out_illegal | output | 1 | Undefined opcode or bad register code |

## Verification
The bench builds the decoder with its default 32-bit word, 8-bit opcode and 3-bit register index. At this size all 256 opcode values can be swept, each with nonzero padding and with the right number of trailing words. The sweep covers every form, every undefined code and every length boundary. Directed cases then add out-of-range register codes, positive and negative offsets, and a consumer that holds off.

// File: rtl/idec_pkg.sv
package idec_pkg;
    parameter int WORD_W   = 32;
    parameter int OPC_W    = 8;
    parameter int FIELD_W  = 8;
    parameter int REG_W    = 3;
    parameter int NUM_REGS = 6;
    parameter int LEN_W    = 2;
    localparam int PARAM_W = WORD_W - OPC_W;

    typedef enum logic [3:0] {
        FORM_NONE, FORM_R, FORM_RR, FORM_RI, FORM_I,
        FORM_II, FORM_SH, FORM_OFF, FORM_BAD
    } form_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [REG_W-1:0]   dst;
        logic [REG_W-1:0]   src;
        logic [WORD_W-1:0]  imm0;
        logic [WORD_W-1:0]  imm1;
        logic [FIELD_W-1:0] shamt;
        logic [WORD_W-1:0]  offset;
        logic [LEN_W-1:0]   len;
        logic               illegal;
    } dec_rec_t;
endpackage

// File: rtl/idec_form.sv
module idec_form
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output form_e            form,
    output logic [1:0]       extra
);
    always_comb begin
        case (opcode) inside
            8'h71, 8'hEE, 8'hFF:                          form = FORM_NONE;
            8'h17, 8'h18, 8'h1F, 8'h61, 8'h62, 8'h72:     form = FORM_R;
            8'h02, 8'h04, 8'h08, [8'h20:8'h26],
            [8'h2A:8'h2E]:                                form = FORM_RR;
            8'h01, 8'h03, 8'h06, 8'h07, [8'h10:8'h16],
            [8'h1A:8'h1C]:                                form = FORM_RI;
            8'h60:                                        form = FORM_I;
            8'h05:                                        form = FORM_II;
            8'h1D, 8'h1E:                                 form = FORM_SH;
            [8'h50:8'h56], 8'h70:                         form = FORM_OFF;
            default:                                      form = FORM_BAD;
        endcase
    end

    always_comb begin
        case (form)
            FORM_RI, FORM_I: extra = 2'd1;
            FORM_II:         extra = 2'd2;
            default:         extra = 2'd0;
        endcase
    end
endmodule

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [PARAM_W-1:0] params,
    input  form_e              form,
    output logic [REG_W-1:0]   dst,
    output logic [REG_W-1:0]   src,
    output logic [FIELD_W-1:0] shamt,
    output logic [WORD_W-1:0]  offset,
    output logic               bad
);
    logic [FIELD_W-1:0] dst_code, src_code;
    logic               use_dst, use_src, dst_ok, src_ok;

    assign dst_code = params[FIELD_W-1:0];
    assign src_code = params[2*FIELD_W-1:FIELD_W];

    assign dst_ok  = (dst_code != '0) && (dst_code <= FIELD_W'(NUM_REGS));
    assign src_ok  = (src_code != '0) && (src_code <= FIELD_W'(NUM_REGS));
    assign use_dst = (form == FORM_R) || (form == FORM_RR) ||
                     (form == FORM_RI) || (form == FORM_SH);
    assign use_src = (form == FORM_RR);

    always_comb begin
        dst    = (use_dst && dst_ok) ? dst_code[REG_W-1:0] : '0;
        src    = (use_src && src_ok) ? src_code[REG_W-1:0] : '0;
        shamt  = (form == FORM_SH) ? src_code : '0;
        offset = (form == FORM_OFF) ? {{OPC_W{params[PARAM_W-1]}}, params} : '0;
        bad    = (form == FORM_BAD) || (use_dst && !dst_ok) || (use_src && !src_ok);
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import idec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OPC_W-1:0]    out_opcode,
    output logic [REG_W-1:0]    out_dst,
    output logic [REG_W-1:0]    out_src,
    output logic [WORD_W-1:0]   out_imm0,
    output logic [WORD_W-1:0]   out_imm1,
    output logic [FIELD_W-1:0]  out_shamt,
    output logic [WORD_W-1:0]   out_offset,
    output logic [LEN_W-1:0]    out_len,
    output logic                out_illegal
);
    typedef enum logic [1:0] {S_HEAD, S_EXT1, S_EXT2, S_OUT} st_e;

    typedef struct packed {
        st_e      st;
        logic     two;
        dec_rec_t rec;
    } state_t;

    state_t q, d;

    form_e              hd_form;
    logic [1:0]         hd_extra;
    logic [REG_W-1:0]   hd_dst, hd_src;
    logic [FIELD_W-1:0] hd_shamt;
    logic [WORD_W-1:0]  hd_offset;
    logic               hd_bad;

    idec_form u_form (
        .opcode (in_data[OPC_W-1:0]),
        .form   (hd_form),
        .extra  (hd_extra)
    );

    idec_fields u_fields (
        .params (in_data[WORD_W-1:OPC_W]),
        .form   (hd_form),
        .dst    (hd_dst),
        .src    (hd_src),
        .shamt  (hd_shamt),
        .offset (hd_offset),
        .bad    (hd_bad)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_HEAD: if (in_valid) begin
                d.rec         = '0;
                d.rec.opcode  = in_data[OPC_W-1:0];
                d.rec.dst     = hd_dst;
                d.rec.src     = hd_src;
                d.rec.shamt   = hd_shamt;
                d.rec.offset  = hd_offset;
                d.rec.illegal = hd_bad;
                d.rec.len     = LEN_W'(hd_extra) + LEN_W'(1);
                d.two         = (hd_extra == 2'd2);
                d.st          = (hd_extra == 2'd0) ? S_OUT : S_EXT1;
            end
            S_EXT1: if (in_valid) begin
                d.rec.imm0 = in_data;
                d.st       = q.two ? S_EXT2 : S_OUT;
            end
            S_EXT2: if (in_valid) begin
                d.rec.imm1 = in_data;
                d.st       = S_OUT;
            end
            S_OUT: if (out_ready) d.st = S_HEAD;
            default: d.st = S_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_HEAD, two: 1'b0, rec: '0};
        end else begin
            q <= d;
        end
    end

    assign in_ready    = (q.st != S_OUT);
    assign out_valid   = (q.st == S_OUT);
    assign out_opcode  = q.rec.opcode;
    assign out_dst     = q.rec.dst;
    assign out_src     = q.rec.src;
    assign out_imm0    = q.rec.imm0;
    assign out_imm1    = q.rec.imm1;
    assign out_shamt   = q.rec.shamt;
    assign out_offset  = q.rec.offset;
    assign out_len     = q.rec.len;
    assign out_illegal = q.rec.illegal;

    // Word counter used only by the checks below
    logic [LEN_W-1:0] words_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                      words_q <= '0;
        else if (out_valid && out_ready) words_q <= '0;
        else if (in_valid && in_ready)   words_q <= words_q + LEN_W'(1);
    end

    // R2
    len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == words_q));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_opcode, out_dst,
            out_src, out_imm0, out_imm1, out_shamt, out_offset, out_len, out_illegal})));

    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    // R5
    three_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(3)) |-> (out_opcode == 8'h05));

    // R12
    shamt_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_opcode != 8'h1D && out_opcode != 8'h1E) |-> (out_shamt == '0));

    // R7
    offset_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_offset[WORD_W-1:PARAM_W-1] == '0 ||
                       out_offset[WORD_W-1:PARAM_W-1] == '1));
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [2:0]  out_dst, out_src;
    logic [31:0] out_imm0, out_imm1, out_offset;
    logic [7:0]  out_shamt;
    logic [1:0]  out_len;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    instr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_dst(out_dst), .out_src(out_src),
        .out_imm0(out_imm0), .out_imm1(out_imm1), .out_shamt(out_shamt),
        .out_offset(out_offset), .out_len(out_len), .out_illegal(out_illegal)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit reg_ok(input logic [7:0] c);
        return (c >= 8'd1) && (c <= 8'd6);
    endfunction

    task automatic push_word(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_instr(input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input bit hold);
        logic [7:0] op, dc, sc;
        bit rr, ri, r1, i1, ii, sh, jm, nn, def, usd, uss, ill;
        int len;
        string tg;
        logic [2:0]  e_dst, e_src;
        logic [31:0] e_i0, e_i1, e_off;
        logic [7:0]  e_sh;
        logic [31:0] snap;
        op = w0[7:0]; dc = w0[15:8]; sc = w0[23:16];
        rr = (op inside {8'h02, 8'h04, 8'h08}) || (op >= 8'h20 && op <= 8'h26) ||
             (op >= 8'h2A && op <= 8'h2E);
        ri = (op inside {8'h01, 8'h03, 8'h06, 8'h07}) || (op >= 8'h10 && op <= 8'h16) ||
             (op >= 8'h1A && op <= 8'h1C);
        r1 = op inside {8'h17, 8'h18, 8'h1F, 8'h61, 8'h62, 8'h72};
        i1 = (op == 8'h60);
        ii = (op == 8'h05);
        sh = op inside {8'h1D, 8'h1E};
        jm = (op >= 8'h50 && op <= 8'h56) || (op == 8'h70);
        nn = op inside {8'h71, 8'hEE, 8'hFF};
        def = rr | ri | r1 | i1 | ii | sh | jm | nn;
        len = ii ? 3 : ((ri | i1) ? 2 : 1);
        usd = rr | ri | r1 | sh;
        uss = rr;
        ill = !def || (usd && !reg_ok(dc)) || (uss && !reg_ok(sc));
        e_dst = (usd && reg_ok(dc)) ? dc[2:0] : 3'd0;
        e_src = (uss && reg_ok(sc)) ? sc[2:0] : 3'd0;
        e_i0  = (len >= 2) ? w1 : 32'd0;
        e_i1  = (len == 3) ? w2 : 32'd0;
        e_sh  = sh ? sc : 8'd0;
        e_off = jm ? {{8{w0[31]}}, w0[31:8]} : 32'd0;
        tg = jm ? "R7" : sh ? "R6" : ii ? "R5" : rr ? "R3" : (ri | r1 | i1) ? "R4" :
             nn ? "R8" : "R9";

        push_word(w0);
        if (len >= 2) push_word(w1);
        if (len == 3) push_word(w2);

        chk(out_valid == 1'b1, "R2", $sformatf("op %h valid after last word", op), out_valid, 1);
        chk(out_len == len[1:0], "R2", $sformatf("op %h len", op), out_len, len);
        chk(out_opcode == op, tg, "opcode", out_opcode, op);
        chk(out_illegal == ill, def ? "R10" : "R9", $sformatf("op %h illegal", op),
            out_illegal, ill);
        chk(out_dst == e_dst, tg, $sformatf("op %h dst", op), out_dst, e_dst);
        chk(out_src == e_src, tg, $sformatf("op %h src", op), out_src, e_src);
        chk(out_imm0 == e_i0, tg, $sformatf("op %h imm0", op), out_imm0, e_i0);
        chk(out_imm1 == e_i1, tg, $sformatf("op %h imm1", op), out_imm1, e_i1);
        chk(out_shamt == e_sh, tg, $sformatf("op %h shamt", op), out_shamt, e_sh);
        chk(out_offset == e_off, tg, $sformatf("op %h offset", op), out_offset, e_off);

        if (hold) begin
            snap = out_imm0 ^ out_offset ^ {out_opcode, out_shamt, 8'(out_len), 8'(out_dst)};
            in_valid = 1'b1;
            in_data  = 32'h0000_00FF;
            repeat (3) @(negedge clk);
            chk(in_ready == 1'b0, "R11", "in_ready while held", in_ready, 0);
            chk(out_valid == 1'b1, "R11", "valid while held", out_valid, 1);
            chk((out_imm0 ^ out_offset ^ {out_opcode, out_shamt, 8'(out_len), 8'(out_dst)})
                == snap, "R11", "record stable", out_imm0, e_i0);
            in_valid = 1'b0;
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R11", "valid cleared after transfer", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // Sweep every opcode with valid register codes and nonzero padding (R12)
        for (int op = 0; op < 256; op++) begin
            logic [7:0] dcode, scode;
            dcode = 8'((op % 6) + 1);
            scode = 8'(((op + 3) % 6) + 1);
            run_instr({8'hA5, scode, dcode, 8'(op)}, 32'h1234_0000 + 32'(op),
                      32'hBEEF_0000 + 32'(op), (op % 17) == 0);
        end

        // R7: positive offset
        run_instr(32'h1234_5650, 0, 0, 1'b0);
        run_instr(32'h0000_0170, 0, 0, 1'b0);
        // R7: most negative offset
        run_instr(32'h8000_0056, 0, 0, 1'b0);
        // R10: bad register codes
        run_instr(32'h0003_0002, 0, 0, 1'b0);
        run_instr(32'h0007_0120, 0, 0, 1'b0);
        run_instr(32'h0000_0001, 32'hCAFE_F00D, 0, 1'b1);
        run_instr(32'h0000_0961, 0, 0, 1'b0);
        run_instr(32'h0003_FF1D, 0, 0, 1'b0);
        run_instr(32'h0000_0717, 0, 0, 1'b0);
        // R12: junk in bits the opcode does not use
        run_instr(32'hFFFF_FF60, 32'h7777_7777, 0, 1'b0);
        run_instr(32'hFFFF_FF71, 0, 0, 1'b0);
        run_instr(32'hFFFF_FF05, 32'h0000_0010, 32'hFFFF_FFFB, 1'b1);
        // R6: shift count extremes
        run_instr(32'h00FF_041E, 0, 0, 1'b0);
        run_instr(32'h0000_061D, 0, 0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule